// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is the serial front and back end of a stereo audio delay path. It watches a bit clock, a word clock and a data line from an upstream source. It oversamples them on a fast system clock and finds bit-clock edges. It recovers one sample word per half-frame and reports each word with a single-cycle strobe and a channel flag. The samples that come back from external storage are shifted out again in the same framing. A downstream receiver can use the same bit and word clocks to read them.

Three framings are supported, picked by a 2-bit selector: I2S, left-justified and right-justified. A fourth code routes the input data line to the output with no register in the path. In right-justified framing, the number of valid bits is set by a 6-bit length input, and any value above 24 is treated as 24. Recovered words are always placed in the top bits of a 24-bit word, and the unused low bits are zero.

Top module: `sap_port`

## Requirements
- R1: While reset is held and right after its release, rx_valid is 0, rx_word is 0 and, in any framing other than pass-through, sdata_out is 0.
- R2: With fmt_sel = 00 (I2S), the half-frame with word clock low is left and the half with word clock high is right. The MSB is on the second rising bit-clock edge after a word-clock change. Up to 24 bits are taken MSB first, and missing low bits read as 0.
- R3: With fmt_sel = 10 (left-justified), word clock high marks left and low marks right. The MSB is on the first rising bit-clock edge that sees the new word-clock level.
- R4: With fmt_sel = 01 (right-justified), the word is the last L bits of the half-frame, LSB on its final rising edge. L is rj_len, with any value above 24 used as 24. The word is placed in the top L bits of rx_word, and L = 0 gives a zero word.
- R5: Data bits outside the word window of a half-frame do not change the recovered word: bits after the 24th in I2S and left-justified, and bits before the last L in right-justified.
- R6: rx_valid is a one-cycle strobe. It is raised for the half-frame that has just ended, after the rising bit-clock edge that starts the next one. rx_right is 1 for a right-channel word and 0 for a left-channel word.
- R7: After reset, the partial half-frame before the first word-clock change yields no strobe. Each later completed half-frame yields exactly one.
- R8: In I2S and left-justified framing, sdata_out carries tx_left in left half-frames and tx_right in right half-frames, MSB first, in the input's framing. It changes only after a falling bit-clock edge.
- R9: In right-justified framing, sdata_out places the top L bits of the tx word at the end of each half-frame, LSB last. The half-frame length is taken from the last one measured, and the other slots carry 0.
- R10: With fmt_sel = 11 (pass-through), sdata_out follows sdata_in combinationally and rx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 right-justified, 10 left-justified, 11 pass-through |
| rj_len | input | 6 | Right-justified word length in bits, values above 24 clamped |
| bclk_in | input | 1 | Serial bit clock |
| wclk_in | input | 1 | Serial word (channel) clock |
| sdata_in | input | 1 | Serial data in |
| tx_left | input | 24 | Left sample to serialize |
| tx_right | input | 24 | Right sample to serialize |
| rx_valid | output | 1 | One-cycle strobe: a word is ready |
| rx_right | output | 1 | Channel of the strobed word, 1 = right |
| rx_word | output | 24 | Recovered word in the top bits, zero-filled below |
| sdata_out | output | 1 | Serial data out |

## Verification
Inputs pass through one sampling register, so a bit-clock edge is seen one system cycle after it occurs. rx_valid and rx_word follow a rising edge one cycle after that. sdata_out follows a falling edge one cycle after that. The bench changes bit-clock levels only on falling system-clock edges and holds each level for four system cycles. It compares sdata_out three cycles after each fall, just before the next rise. It records strobed words on the falling edge of every system cycle, so the two-cycle latency never overlaps a check. Pass-through is checked one time unit after sdata_in changes, with no clock edge between the change and the check.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_BYP = 2'b11
  } fmt_e;
endpackage

// File: rtl/sap_edge.sv
module sap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdat_i,
  output logic rise_o,
  output logic fall_o,
  output logic wclk_o,
  output logic sdat_o
);
  logic [2:0] smp_q, smp_d;
  logic       bprev_q;

  always_comb smp_d = {bclk_i, wclk_i, sdat_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      bprev_q <= 1'b0;
    end else begin
      smp_q   <= smp_d;
      bprev_q <= smp_q[2];
    end
  end

  assign rise_o = smp_q[2] & ~bprev_q;
  assign fall_o = ~smp_q[2] & bprev_q;
  assign wclk_o = smp_q[1];
  assign sdat_o = smp_q[0];
endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic [LEN_W-1:0]  rj_len,
  input  logic              rise,
  input  logic              wclk_s,
  input  logic              sdat_s,
  output logic              rx_valid,
  output logic              rx_right,
  output logic [WORD_W-1:0] rx_word,
  output logic              frm_lvl,
  output logic              wclk_last,
  output logic              armed,
  output logic              len_ok,
  output logic [CNT_W-1:0]  bit_idx,
  output logic [CNT_W-1:0]  half_len
);
  logic [1:0]        warm_q, warm_d;
  logic              f_q, wck_q, f_now, trans, emit;
  logic [CNT_W-1:0]  cnt_q, cnt_d, hlen_q, hlen_d;
  logic [WORD_W-1:0] cap_q, cap_d, rjsh_q, rj_word, word_q, word_d;
  logic              vld_q, vld_d, right_q, right_d, lok_q, lok_d;
  int                lc, idx;

  always_comb begin
    // framing level: 1 = left half; I2S uses word clock from the prior edge
    f_now = (fmt == FMT_I2S) ? ~wck_q : wclk_s;
    trans = (warm_q >= 2'd2) && (f_now != f_q);
    lc    = (int'(rj_len) > WORD_W) ? WORD_W : int'(rj_len);

    rj_word = '0;
    for (int i = 0; i < WORD_W; i++)
      if (i >= WORD_W - lc) rj_word[i] = rjsh_q[i - WORD_W + lc];

    cap_d = cap_q;
    idx   = WORD_W - 1 - int'(cnt_q);
    if (trans) begin
      cap_d = '0;
      cap_d[WORD_W-1] = sdat_s;
    end else if (int'(cnt_q) < WORD_W) begin
      cap_d[idx] = sdat_s;
    end

    cnt_d  = trans ? CNT_W'(1) : ((cnt_q == '1) ? cnt_q : cnt_q + 1'b1);
    warm_d = warm_q;
    if (warm_q < 2'd2)  warm_d = warm_q + 2'd1;
    else if (trans)     warm_d = 2'd3;

    emit    = rise && trans && (warm_q == 2'd3) && (fmt != FMT_BYP);
    vld_d   = emit;
    word_d  = emit ? ((fmt == FMT_RJ) ? rj_word : cap_q) : word_q;
    right_d = emit ? ~f_q : right_q;
    hlen_d  = (rise && trans) ? cnt_q : hlen_q;
    lok_d   = lok_q | (rise && trans && (warm_q == 2'd3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0; f_q <= 1'b0; wck_q <= 1'b0; cnt_q <= '0;
      cap_q <= '0; rjsh_q <= '0; vld_q <= 1'b0; right_q <= 1'b0;
      word_q <= '0; hlen_q <= '0; lok_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      word_q  <= word_d;
      right_q <= right_d;
      hlen_q  <= hlen_d;
      lok_q   <= lok_d;
      if (rise) begin
        f_q    <= f_now;
        wck_q  <= wclk_s;
        cnt_q  <= cnt_d;
        cap_q  <= cap_d;
        rjsh_q <= {rjsh_q[WORD_W-2:0], sdat_s};
        warm_q <= warm_d;
      end
    end
  end

  assign rx_valid  = vld_q;
  assign rx_right  = right_q;
  assign rx_word   = word_q;
  assign frm_lvl   = f_q;
  assign wclk_last = wck_q;
  assign armed     = (warm_q == 2'd3);
  assign len_ok    = lok_q;
  assign bit_idx   = cnt_q;
  assign half_len  = hlen_q;

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6
  strobe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise));
  // R10
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_BYP) |=> !rx_valid);
  // R4
  rj_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(fmt == FMT_RJ) && ($past(rj_len) == '0)) |-> (rx_word == '0));
endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic [LEN_W-1:0]  rj_len,
  input  logic              fall,
  input  logic              wclk_s,
  input  logic              wclk_last,
  input  logic              frm_lvl,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [CNT_W-1:0]  half_len,
  input  logic              armed,
  input  logic              len_ok,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sout
);
  logic              f_n, tn, bit_v, sout_q, sout_d;
  logic [WORD_W-1:0] word, hold_q, hold_d;
  int                k, n, j, lc;

  always_comb begin
    // predict the framing of the coming rising edge
    f_n   = (fmt == FMT_I2S) ? ~wclk_last : wclk_s;
    tn    = (f_n != frm_lvl);
    k     = tn ? 0 : int'(bit_idx);
    word  = tn ? (f_n ? tx_left : tx_right) : hold_q;
    lc    = (int'(rj_len) > WORD_W) ? WORD_W : int'(rj_len);
    n     = int'(half_len);
    j     = n - 1 - k;
    bit_v = 1'b0;
    if (fmt == FMT_RJ) begin
      if (len_ok && (k < n) && (j >= 0) && (j < lc)) bit_v = word[WORD_W - lc + j];
    end else begin
      if (k < WORD_W) bit_v = word[WORD_W - 1 - k];
    end
    sout_d = fall ? (armed & bit_v) : sout_q;
    hold_d = (fall && tn) ? word : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sout_q <= 1'b0;
      hold_q <= '0;
    end else begin
      sout_q <= sout_d;
      hold_q <= hold_d;
    end
  end

  assign sout = sout_q;

  // R8
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sout_q) |-> $past(fall));
endmodule

// File: rtl/sap_port.sv
module sap_port
  import sap_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int HALF_MAX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic [LEN_W-1:0]  rj_len,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              sdata_in,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              rx_valid,
  output logic              rx_right,
  output logic [WORD_W-1:0] rx_word,
  output logic              sdata_out
);
  localparam int CNT_W = $clog2(HALF_MAX + 1);

  fmt_e             fmt;
  logic             rise, fall, wclk_s, sdat_s;
  logic             frm_lvl, wclk_last, armed, len_ok, sout;
  logic [CNT_W-1:0] bit_idx, half_len;

  assign fmt = fmt_e'(fmt_sel);

  sap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_in), .wclk_i(wclk_in), .sdat_i(sdata_in),
    .rise_o(rise), .fall_o(fall), .wclk_o(wclk_s), .sdat_o(sdat_s)
  );

  sap_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .rj_len(rj_len), .rise(rise),
    .wclk_s(wclk_s), .sdat_s(sdat_s), .rx_valid(rx_valid), .rx_right(rx_right),
    .rx_word(rx_word), .frm_lvl(frm_lvl), .wclk_last(wclk_last), .armed(armed),
    .len_ok(len_ok), .bit_idx(bit_idx), .half_len(half_len)
  );

  sap_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .rj_len(rj_len), .fall(fall),
    .wclk_s(wclk_s), .wclk_last(wclk_last), .frm_lvl(frm_lvl), .bit_idx(bit_idx),
    .half_len(half_len), .armed(armed), .len_ok(len_ok), .tx_left(tx_left),
    .tx_right(tx_right), .sout(sout)
  );

  // R10: pass-through has no register in the path
  assign sdata_out = (fmt == FMT_BYP) ? sdata_in : sout;
endmodule

// File: tb/sap_port_tb.sv
module sap_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALFS      = 10;
  localparam int MAXE       = HALFS * 32;
  localparam int WDOG       = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic [5:0]  rj_len;
  logic        bclk_in, wclk_in, sdata_in;
  logic [23:0] tx_left, tx_right;
  logic        rx_valid, rx_right, sdata_out;
  logic [23:0] rx_word;

  int   errors = 0;
  int   checks = 0;
  int   got = 0;
  bit   dbl = 1'b0;
  logic prev_v = 1'b0;
  logic clr = 1'b0;
  logic [23:0] got_w [0:15];
  logic        got_r [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  sap_port u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .rj_len(rj_len),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata_in(sdata_in),
    .tx_left(tx_left), .tx_right(tx_right), .rx_valid(rx_valid),
    .rx_right(rx_right), .rx_word(rx_word), .sdata_out(sdata_out)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (clr) begin
      got = 0;
      dbl = 1'b0;
    end else if (rx_valid) begin
      if (got < 16) begin
        got_w[got] = rx_word;
        got_r[got] = rx_right;
      end
      got = got + 1;
      if (prev_v) dbl = 1'b1;
    end
    prev_v = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tx(input logic [1:0] fm, input int n, input int lc,
                                  input int k, input logic [23:0] w);
    int j;
    j = n - 1 - k;
    if (fm == 2'b01) return (j >= 0 && j < lc) ? w[24 - lc + j] : 1'b0;
    return (k < 24) ? w[23 - k] : 1'b0;
  endfunction

  task automatic play_run(input logic [1:0] fm, input int n, input int lraw, input string tag);
    int lc, total, h, k;
    logic [31:0] rnd;
    logic [23:0] w, msk, expw [0:HALFS-1];
    logic fv [0:MAXE-1];
    logic dv [0:MAXE-1];
    logic wv [0:MAXE-1];
    string otag;
    lc   = (lraw > 24) ? 24 : lraw;
    otag = (fm == 2'b01) ? "R9" : ((fm == 2'b11) ? "R10" : "R8");
    @(negedge clk);
    bclk_in = 1'b0; wclk_in = 1'b0; sdata_in = 1'b0;
    rst_n = 1'b0; fmt_sel = fm; rj_len = lraw[5:0];
    rnd = $urandom; tx_left = rnd[23:0];
    rnd = $urandom; tx_right = rnd[23:0];
    clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    if (fm != 2'b11)
      chk(rx_valid == 1'b0 && rx_word == 24'h0 && sdata_out == 1'b0, "R1",
          {7'h0, rx_valid, rx_word}, 32'h0);

    total = 0;
    for (int hh = 0; hh < HALFS; hh++) begin
      rnd = $urandom; w = rnd[23:0];
      msk = (24'd1 << lc) - 24'd1;
      if (fm == 2'b01) expw[hh] = (lc == 0) ? 24'h0 : ((w & msk) << (24 - lc));
      else expw[hh] = (n >= 24) ? w : ((w >> (24 - n)) << (24 - n));
      for (int kk = 0; kk < n; kk++) begin
        rnd = $urandom;
        fv[total] = (hh % 2 == 0);
        if (fm == 2'b01) dv[total] = ((n - 1 - kk) < lc) ? w[n - 1 - kk] : rnd[0];
        else dv[total] = (kk < 24) ? w[23 - kk] : rnd[0];
        total++;
      end
    end
    for (int e = 0; e < total; e++) begin
      if (fm == 2'b00) wv[e] = (e + 1 < total) ? ~fv[e + 1] : fv[e];
      else wv[e] = fv[e];
    end

    for (int e = 0; e < total; e++) begin
      h = e / n; k = e % n;
      bclk_in = 1'b0; wclk_in = wv[e]; sdata_in = dv[e];
      repeat (3) @(negedge clk);
      if (fm == 2'b11)
        chk(sdata_out == dv[e], otag, {31'h0, sdata_out}, {31'h0, dv[e]});
      else if (h >= 3)
        chk(sdata_out == exp_tx(fm, n, lc, k, fv[e] ? tx_left : tx_right), otag,
            {31'h0, sdata_out}, {31'h0, exp_tx(fm, n, lc, k, fv[e] ? tx_left : tx_right)});
      @(negedge clk);
      bclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    bclk_in = 1'b0;
    repeat (6) @(negedge clk);

    if (fm == 2'b11) begin
      chk(got == 0, "R10", got, 0);
    end else begin
      chk(got == HALFS - 2, "R7", got, HALFS - 2);
      chk(!dbl, "R6", {31'h0, dbl}, 0);
      for (int i = 0; i < HALFS - 2 && i < 16; i++) begin
        chk(got_w[i] == expw[i + 1], tag, {8'h0, got_w[i]}, {8'h0, expw[i + 1]});
        chk(got_r[i] == ((i + 1) % 2 == 1), "R6", {31'h0, got_r[i]}, (i + 1) % 2);
      end
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    logic [1:0]  fm;
    int          n, l;
    rnd = $urandom(32'd31337);
    rst_n = 1'b0; fmt_sel = 2'b10; rj_len = '0;
    bclk_in = 1'b0; wclk_in = 1'b0; sdata_in = 1'b0;
    tx_left = '0; tx_right = '0;
    repeat (3) @(negedge clk);

    play_run(2'b00, 32, 0, "R2");
    play_run(2'b00, 16, 0, "R2");
    play_run(2'b10, 24, 0, "R3");
    play_run(2'b10, 32, 0, "R5");
    play_run(2'b01, 32, 24, "R4");
    play_run(2'b01, 32, 40, "R4");
    play_run(2'b01, 16, 16, "R4");
    play_run(2'b01, 24, 0, "R4");
    play_run(2'b01, 32, 12, "R5");
    play_run(2'b11, 32, 0, "R10");

    // pass-through with no clock edge between change and check
    for (int i = 0; i < 8; i++) begin
      rnd = $urandom;
      sdata_in = rnd[0];
      #1;
      chk(sdata_out == rnd[0], "R10", {31'h0, sdata_out}, {31'h0, rnd[0]});
    end

    for (int r = 0; r < 5; r++) begin
      rnd = $urandom; fm = 2'(rnd % 3);
      rnd = $urandom; n = 16 + 8 * int'(rnd % 3);
      rnd = $urandom; l = (fm == 2'b01) ? int'(rnd % (n + 1)) : 0;
      play_run(fm, n, l, (fm == 2'b00) ? "R2" : ((fm == 2'b01) ? "R4" : "R3"));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule